// File: doc/BRIEF.md
# MDIO Management Frame Master

This block acts as the station side of a two-wire MII management bus. A host pulses `start` with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs one complete management frame. It generates the management clock `mdc` and controls the data line through a separate output value and output-enable, so that an I/O pad outside the block can form the bidirectional line.

Each frame is built from bit slots. In every slot the data line is first set up while `mdc` is low for one half-period, and then `mdc` is high for one half-period. A frame opens with a long run of ones, followed by the start and opcode fields and the two addresses. A read then releases the line for the turnaround, samples 16 bits from the PHY, and spends one trailing clock with the line released. A write drives the turnaround and the 16 data bits itself, then releases the line for one trailing clock. The half-period is `half_div + 1` system clocks. It is captured when the frame is accepted.

While a frame runs, `busy` stays high. A one-cycle `done` pulse ends the frame, and a read result stays on `rdata` until the next read replaces it.

Top module: `mdio_frame_master`

## Requirements
- R1: While reset is active and right after it, `mdc`, `mdio_oe`, `busy` and `done` are 0, and `rdata` is 0.
- R2: Every frame begins with 40 `mdc` pulses, and for each of them the line is driven (`mdio_oe`=1) with value 1.
- R3: Pulses 40 and 41 carry the start field 0 then 1. Pulses 42 and 43 carry the opcode: 1 then 0 for a read (`rd_nwr`=1), and 0 then 1 for a write (`rd_nwr`=0).
- R4: Pulses 44 to 48 carry `phy_addr` bit 4 down to bit 0. Pulses 49 to 53 carry `reg_addr` bit 4 down to bit 0.
- R5: Each low half and each high half of `mdc` lasts exactly `half_div + 1` system clocks. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R6: On a read, `mdio_oe` is 0 from pulse 54 onward. Pulse 54 is the turnaround. The value on `mdio_i` at the falling edge of pulses 55 to 70 becomes `rdata` bit 15 down to bit 0.
- R7: On a write, pulses 54 and 55 are driven as 1 then 0. Pulses 56 to 71 are driven with `wdata` bit 15 down to bit 0.
- R8: The last pulse of a frame (pulse 71 for a read, pulse 72 for a write) has `mdio_oe`=0. At its falling edge `busy` drops and `done` is high for exactly one cycle, with no further pulses.
- R9: A `start` pulse while `busy` is high is ignored. The running frame keeps its fields and produces exactly one `done`.
- R10: `rdata` holds its value while idle and is not changed by a write frame.
- R11: Whenever `busy` is low, `mdc` and `mdio_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run a frame |
| rd_nwr | input | 1 | 1 selects a read frame, 0 a write frame |
| phy_addr | input | 5 | PHY address of the frame |
| reg_addr | input | 5 | Register address of the frame |
| wdata | input | 16 | Data for a write frame |
| half_div | input | HALF_W | MDC half-period minus one, in system clocks |
| mdio_i | input | 1 | Sampled level of the data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | 1 drives the data line, 0 releases it |
| rdata | output | 16 | Data from the last read frame |
| busy | output | 1 | High while a frame runs |
| done | output | 1 | One-cycle pulse at frame completion |

## Verification
The bench sweeps every PHY and register address value on reads, and returns a different pattern each time, to catch a swapped address order or a bit taken from the turnaround pulse. A sampling point off by one would give `rdata` shifted by one bit. Writes run under several divider settings and data patterns, which exposes a half-period miscount, a trailing clock that is lost or still driven, and turnaround bits that are reversed. A second `start` in the middle of a frame would corrupt the fields or add a `done` if the block accepted it. A write that is followed by a check of `rdata` shows whether the read register leaks.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } mdio_op_e;

  // start (2) + opcode (2) + PHY address (5) + register address (5)
  localparam int ADDR_BITS      = 5;
  localparam int HDR_FIELD_BITS = 4 + 2 * ADDR_BITS;
  localparam int TA_BITS        = 2;
  localparam int DATA_BITS      = 16;
endpackage

// File: rtl/mdio_halfclk.sv
module mdio_halfclk #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] lim_in,
  output logic         tick
);
  logic [W-1:0] lim_q, cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    tick   = run && (cnt_q == lim_q);
    cnt_en = load | run;
    if (load || tick) cnt_d = '0;
    else              cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load)   lim_q <= lim_in;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/mdio_rx.sv
module mdio_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  output logic [DW-1:0] data
);
  logic [DW-1:0] data_q, data_d;

  always_comb data_d = {data_q[DW-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (shift_en) data_q <= data_d;
  end

  assign data = data_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 rd_nwr,
  input  logic [ADDR_BITS-1:0] phy_addr,
  input  logic [ADDR_BITS-1:0] reg_addr,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 tick,
  output logic                 accept,
  output logic                 sample_en,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 busy,
  output logic                 done
);
  localparam int HDR_SLOTS = PRE_BITS + HDR_FIELD_BITS;
  localparam int FRAME_W   = HDR_SLOTS + TA_BITS + DATA_BITS;
  localparam int RD_LAST   = HDR_SLOTS + DATA_BITS + 1;
  localparam int WR_LAST   = HDR_SLOTS + TA_BITS + DATA_BITS;
  localparam int SLOT_W    = $clog2(WR_LAST + 1);

  localparam logic [SLOT_W-1:0] S_HDR     = SLOT_W'(HDR_SLOTS);
  localparam logic [SLOT_W-1:0] S_RD_D0   = SLOT_W'(HDR_SLOTS + 1);
  localparam logic [SLOT_W-1:0] S_RD_DN   = SLOT_W'(HDR_SLOTS + DATA_BITS);
  localparam logic [SLOT_W-1:0] S_RD_LAST = SLOT_W'(RD_LAST);
  localparam logic [SLOT_W-1:0] S_WR_LAST = SLOT_W'(WR_LAST);

  mdio_op_e           op_q, op_d;
  logic               busy_q, busy_d, done_q, done_d, mdc_q, mdc_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               last_slot, in_rd_data, state_en;

  always_comb begin
    accept     = start && !busy_q;
    last_slot  = (op_q == OP_READ) ? (slot_q == S_RD_LAST) : (slot_q == S_WR_LAST);
    in_rd_data = (op_q == OP_READ) && (slot_q >= S_RD_D0) && (slot_q <= S_RD_DN);
    op_d       = op_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    mdc_d      = mdc_q;
    slot_d     = slot_q;
    frame_d    = frame_q;
    sample_en  = 1'b0;
    if (accept) begin
      op_d    = mdio_op_e'(rd_nwr);
      busy_d  = 1'b1;
      mdc_d   = 1'b0;
      slot_d  = '0;
      frame_d = {{PRE_BITS{1'b1}}, 2'b01, rd_nwr ? 2'b10 : 2'b01,
                 phy_addr, reg_addr, 2'b10, wdata};
    end else if (busy_q && tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
      end else begin
        mdc_d     = 1'b0;
        sample_en = in_rd_data;
        if (last_slot) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          slot_d  = slot_q + SLOT_W'(1);
          frame_d = {frame_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
    state_en = accept || (busy_q && tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_WRITE;
      busy_q  <= 1'b0;
      mdc_q   <= 1'b0;
      slot_q  <= '0;
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (state_en) begin
        op_q    <= op_d;
        busy_q  <= busy_d;
        mdc_q   <= mdc_d;
        slot_q  <= slot_d;
        frame_q <= frame_d;
      end
    end
  end

  always_comb begin
    mdc     = mdc_q;
    busy    = busy_q;
    done    = done_q;
    mdio_o  = frame_q[FRAME_W-1];
    mdio_oe = busy_q && (slot_q < ((op_q == OP_READ) ? S_HDR : S_WR_LAST));
  end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int PRE_BITS = 40,
  parameter int HALF_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [4:0]        phy_addr,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       wdata,
  input  logic [HALF_W-1:0] half_div,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [15:0]       rdata,
  output logic              busy,
  output logic              done
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       accept, tick, sample_en, busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  mdio_halfclk #(.W(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .load(accept), .run(busy_w),
    .lim_in(half_div), .tick(tick)
  );

  mdio_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata), .tick(tick),
    .accept(accept), .sample_en(sample_en), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(busy_w), .done(done)
  );

  mdio_rx #(.DW(16)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .shift_en(sample_en), .din(mdio_i), .data(rdata)
  );

  assign busy = busy_w;
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rdata,
  input logic        busy,
  input logic        done
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_line_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rdata));
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .rdata(rdata), .busy(busy), .done(done)
);

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
  logic        clk, rst_n, start, rd_nwr, mdio_i;
  logic [4:0]  phy_addr, reg_addr;
  logic [15:0] wdata, rdata;
  logic [7:0]  half_div;
  logic        mdc, mdio_o, mdio_oe, busy, done;

  mdio_frame_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata), .half_div(half_div),
    .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rdata(rdata), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int np, hirun, lorun, terr, stab, ndone, mdiv;
  logic rec_o [0:79];
  logic rec_oe[0:79];
  logic resp_rd, mdc_p, o_p, oe_p;
  logic [15:0] resp_val;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  // monitor and PHY responder, sampling away from the active edge
  always @(negedge clk) begin
    if (mdc && !mdc_p) begin
      if (np < 80) begin rec_o[np] = mdio_o; rec_oe[np] = mdio_oe; end
      if (lorun != mdiv + 1) terr++;
      lorun = 0;
      if (resp_rd && np >= 55 && np <= 70) mdio_i = resp_val[15 - (np - 55)];
      else mdio_i = 1'b1;
      np++;
    end
    if (mdc) hirun++;
    else if (mdc_p) begin
      if (hirun != mdiv + 1) terr++;
      hirun = 0;
    end
    if (busy && !mdc) lorun++;
    if (!busy) lorun = 0;
    if (mdc && mdc_p && (mdio_o != o_p || mdio_oe != oe_p)) stab++;
    if (done) ndone++;
    mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
  end

  function automatic logic exp_bit(input int p, input logic rd, input logic [4:0] pa,
                                   input logic [4:0] ra, input logic [15:0] wd);
    if (p < 40) return 1'b1;
    if (p == 40) return 1'b0;
    if (p == 41) return 1'b1;
    if (p == 42) return rd;
    if (p == 43) return !rd;
    if (p < 49) return pa[4 - (p - 44)];
    if (p < 54) return ra[4 - (p - 49)];
    if (p == 54) return 1'b1;
    if (p == 55) return 1'b0;
    return wd[15 - (p - 56)];
  endfunction

  task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rv,
                           input int dv, input bit poke);
    int w, npre, nhdr, naddr, nwd, noe, exp_np;
    logic [15:0] rd_at_done;
    logic busy_at_done;
    @(negedge clk);
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd; half_div = 8'(dv);
    resp_rd = rd; resp_val = rv; mdiv = dv;
    np = 0; hirun = 0; lorun = 0; terr = 0; stab = 0; ndone = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; rd_nwr = !rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 30000) begin @(negedge clk); w++; end
    chk(w < 30000, "R8 done timeout", w, 0);
    rd_at_done = rdata; busy_at_done = busy;
    repeat (4) @(negedge clk);
    exp_np = rd ? 72 : 73;
    chk(np == exp_np, "R8 pulse count", np, exp_np);
    npre = 0; nhdr = 0; naddr = 0; nwd = 0; noe = 0;
    for (int p = 0; p < 80; p++) begin
      if (p < np && p < exp_np) begin
        logic eoe;
        eoe = rd ? (p < 54) : (p < 72);
        if (rec_oe[p] != eoe) noe++;
        if (eoe && rec_o[p] != exp_bit(p, rd, pa, ra, wd)) begin
          if (p < 40) npre++;
          else if (p < 44) nhdr++;
          else if (p < 54) naddr++;
          else nwd++;
        end
      end
    end
    chk(npre == 0, "R2 preamble bits", npre, 0);
    chk(nhdr == 0, "R3 start/opcode bits", nhdr, 0);
    chk(naddr == 0, "R4 address bits", naddr, 0);
    if (!rd) chk(nwd == 0, "R7 turnaround/data bits", nwd, 0);
    chk(noe == 0, rd ? "R6 release / R8 trailing oe" : "R7 drive / R8 trailing oe", noe, 0);
    chk(terr == 0 && stab == 0, "R5 half-period/hold", terr * 256 + stab, 0);
    chk(ndone == 1 && !busy_at_done, "R8 single done", ndone, 1);
    if (rd) chk(rd_at_done == rv, "R6 read data", rd_at_done, rv);
    chk(!mdc && !mdio_oe && !busy, "R11 idle lines", {mdc, mdio_oe, busy}, 0);
    if (poke) chk(ndone == 1 && npre + nhdr + naddr + nwd == 0, "R9 start while busy",
                  ndone, 1);
  endtask

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; start = 1'b0; rd_nwr = 1'b0; phy_addr = '0; reg_addr = '0;
    wdata = '0; half_div = '0; mdio_i = 1'b1; resp_rd = 1'b0; resp_val = '0;
    np = 0; hirun = 0; lorun = 0; terr = 0; stab = 0; ndone = 0; mdiv = 0;
    mdc_p = 1'b0; o_p = 1'b0; oe_p = 1'b0;
    repeat (3) @(negedge clk);
    chk({mdc, mdio_oe, busy, done} == 4'b0 && rdata == 16'h0, "R1 during reset",
        {mdc, mdio_oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({mdc, mdio_oe, busy, done} == 4'b0 && rdata == 16'h0, "R1 after reset",
        rdata, 0);
    // reads across every address value
    for (int a = 0; a < 32; a++)
      run_frame(1'b1, 5'(a), 5'(31 - a), 16'h0, 16'(a * 16'h0841 ^ 16'hA5C3), 0, 1'b0);
    // writes with assorted data and dividers
    for (int k = 0; k < 8; k++)
      run_frame(1'b0, 5'(1 << (k % 5)), 5'(k * 3), 16'(16'h8001 << k | k), 16'h0, 1, 1'b0);
    run_frame(1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0, 3, 1'b0);
    run_frame(1'b0, 5'h0A, 5'h15, 16'h0000, 16'h0, 2, 1'b0);
    // read, then a write must leave rdata alone
    run_frame(1'b1, 5'h1F, 5'h00, 16'h0, 16'h8001, 2, 1'b0);
    held = rdata;
    run_frame(1'b0, 5'h03, 5'h11, 16'h5AA5, 16'h0, 1, 1'b0);
    chk(rdata == held && held == 16'h8001, "R10 rdata kept across write", rdata, held);
    repeat (20) @(negedge clk);
    chk(rdata == 16'h8001, "R10 rdata held idle", rdata, 16'h8001);
    // requests while busy
    run_frame(1'b1, 5'h12, 5'h09, 16'h0, 16'h3C96, 1, 1'b1);
    run_frame(1'b0, 5'h07, 5'h1C, 16'hC3E1, 16'h0, 0, 1'b1);
    chk(rdata == 16'h3C96, "R10 rdata after poked write", rdata, 16'h3C96);
    finish_run();
  end
endmodule